// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside the pins of a four-bank synchronous DRAM. It samples clock enable, chip select, the row strobe, the column strobe, write enable, the two bank-select bits and the twelve address bits on every rising clock edge. It turns each sample into one command and keeps a model of the device's state. That model holds, for each bank, whether a row is open and which row it is. It also tracks the burst in flight, the programmed burst length and the power state: running, powered down or self refreshing. A controller or a monitor can use the outputs to follow what the memory is doing and to catch commands that are not allowed in the current state.

A rejected command is still reported on the strobe, and it raises the illegal flag. It changes no state. Every output is registered, so it shows the result of the edge that has just passed. Memory arrays, data paths and analog timing are not modelled.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: On each edge where clock enable was high in the previous cycle and is high now, the block decodes chip select low with {RAS,CAS,WE} as follows: 111 no-op, 011 activate, 101 read, 100 write, 010 precharge, 000 mode set, 001 refresh. A10 high turns a read or write into its auto-precharge form, and a precharge into precharge-all. Chip select high is a deselect. Pattern 110 gives the no-op strobe with the illegal flag. The result appears one cycle after the edge on `cmd_o`, with at most one bit set. The bit order is: 0 no-op, 1 deselect, 2 activate, 3 read, 4 read+AP, 5 write, 6 write+AP, 7 precharge, 8 precharge-all, 9 mode set, 10 refresh, 11 self-refresh entry, 12 self-refresh exit, 13 power-down entry, 14 power-down exit. `bank_o` mirrors BA.
- R2: An activate to an idle bank opens that bank and stores A11..A0 as its row. An activate to an open bank is illegal and leaves every bank unchanged.
- R3: A read or write to an open bank is accepted, and `addr_o` carries only A8..A0 (bits 11..9 are zero). A read or write to an idle bank is illegal and changes nothing.
- R4: A precharge with A10 low closes only the addressed bank. With A10 high it closes all four banks, whatever BA holds.
- R5: A mode set is accepted only when all banks are idle and A2 is low. It then loads the burst-length code from A1..A0, where 0, 1, 2 and 3 mean 1, 2, 4 and 8 beats. The code after reset is 0.
- R6: An accepted read or write starts a burst of the programmed length. With auto-precharge, the bank closes on the edge that is the burst-length-th active edge after the command. While such a burst runs, any read or write is illegal. A precharge that covers that bank cancels the pending close. A plain burst may be replaced by a new read or write.
- R7: Refresh is legal only when all banks are idle. The refresh pattern with clock enable falling from high to low is self-refresh entry, and it is also legal only when all banks are idle. While clock enable stays low, no strobe appears. The first high sample gives self-refresh exit.
- R8: A no-op or deselect with clock enable falling enters power-down, and bank state is kept. It is illegal while a burst is running. While clock enable stays low, no strobe appears. The first high sample gives power-down exit.
- R9: Clock enable falling with any other command gives that command's strobe with the illegal flag and no state change. While running, a cycle whose previous clock enable was low is a suspended cycle: it gives no strobe, and the burst count is frozen.
- R10: A deselect ignores the strobes and address, but a burst in progress keeps counting and an auto-precharge still completes.
- R11: During and straight after reset, `cmd_o` and `illegal_o` are zero, all banks are idle, all stored rows are zero, and the previous clock enable is taken as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank select |
| addr_i | input | 12 | Address pins |
| cmd_o | output | 15 | One-hot command strobe |
| illegal_o | output | 1 | Strobed command was rejected |
| bank_o | output | 2 | Registered bank select |
| addr_o | output | 12 | Row, or column on read/write |
| bank_open_o | output | 4 | Per-bank open flag |
| bank_row_o | output | 48 | Stored row per bank, bank 0 in the low bits |

## Verification
The assertions take the decoded pin activity as coming from a single memory on one bus. Any pin combination is legal input, because the block must flag bad sequences rather than rely on their absence. The properties tie an accepted activate, precharge, mode set or self-refresh entry to the bank flags, and they tie read and write strobes to a masked column. Directed sequences reach every state and timing corner: burst-end closure, cancellation, suspension, and both low-power modes. A long stretch of random pin patterns follows. In that stretch clock enable drops only now and then, so the power modes are entered and left many times without stalling the run.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  typedef enum logic [3:0] {
    CMD_NOP, CMD_DSL, CMD_ACT, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_PRE,
    CMD_PALL, CMD_MRS, CMD_REF, CMD_SRE, CMD_SRX, CMD_PDE, CMD_PDX, CMD_NONE
  } cmd_e;
  localparam int unsigned NUM_CMD = 15;
  typedef enum logic [1:0] {PWR_RUN, PWR_DOWN, PWR_SELF} pwr_e;
endpackage

// File: rtl/sdram_trk_decode.sv
module sdram_trk_decode
  import sdram_trk_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ap_i,
  input  logic cke_prev_i,
  input  logic cke_i,
  input  pwr_e pwr_i,
  output cmd_e cmd_o,
  output logic bad_o
);
  cmd_e pat;
  logic pat_bad;

  always_comb begin
    pat_bad = 1'b0;
    if (cs_ni) pat = CMD_DSL;
    else begin
      case ({ras_ni, cas_ni, we_ni})
        3'b111:  pat = CMD_NOP;
        3'b011:  pat = CMD_ACT;
        3'b101:  pat = ap_i ? CMD_RDA : CMD_RD;
        3'b100:  pat = ap_i ? CMD_WRA : CMD_WR;
        3'b010:  pat = ap_i ? CMD_PALL : CMD_PRE;
        3'b000:  pat = CMD_MRS;
        3'b001:  pat = CMD_REF;
        default: begin pat = CMD_NOP; pat_bad = 1'b1; end
      endcase
    end
  end

  always_comb begin
    cmd_o = pat;
    bad_o = pat_bad;
    if (pwr_i != PWR_RUN) begin
      // low-power: only the rising clock enable matters
      bad_o = 1'b0;
      if (!cke_i)                cmd_o = CMD_NONE;
      else if (pwr_i == PWR_DOWN) cmd_o = CMD_PDX;
      else                       cmd_o = CMD_SRX;
    end else if (!cke_prev_i) begin
      cmd_o = CMD_NONE;
      bad_o = 1'b0;
    end else if (!cke_i) begin
      if ((pat == CMD_NOP || pat == CMD_DSL) && !pat_bad) cmd_o = CMD_PDE;
      else if (pat == CMD_REF)                           cmd_o = CMD_SRE;
      else                                               bad_o = 1'b1;
    end
  end
endmodule

// File: rtl/sdram_trk_burst.sv
module sdram_trk_burst #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned BL_CODE_W = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   start_i,
  input  logic                   start_ap_i,
  input  logic [BANK_W-1:0]      start_bank_i,
  input  logic                   mrs_i,
  input  logic [BL_CODE_W-1:0]   bl_code_i,
  input  logic [(1<<BANK_W)-1:0] cancel_mask_i,
  output logic                   busy_o,
  output logic                   ap_busy_o,
  output logic [(1<<BANK_W)-1:0] close_mask_o
);
  localparam int unsigned MAX_BL = 1 << ((1 << BL_CODE_W) - 1);
  localparam int unsigned CNT_W  = $clog2(MAX_BL + 1);

  logic [CNT_W-1:0]     cnt_q;
  logic [BL_CODE_W-1:0] code_q;
  logic                 ap_q;
  logic [BANK_W-1:0]    ap_bank_q;
  logic                 close;

  assign busy_o    = (cnt_q != '0);
  assign ap_busy_o = busy_o && ap_q;
  assign close     = tick_i && (cnt_q == CNT_W'(1)) && ap_q;

  always_comb begin
    close_mask_o = '0;
    close_mask_o[ap_bank_q] = close;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      code_q    <= '0;
      ap_q      <= 1'b0;
      ap_bank_q <= '0;
    end else begin
      if (mrs_i) code_q <= bl_code_i;
      if (start_i) begin
        cnt_q     <= CNT_W'(1) << code_q;
        ap_q      <= start_ap_i;
        ap_bank_q <= start_bank_i;
      end else begin
        if (tick_i && busy_o) cnt_q <= cnt_q - CNT_W'(1);
        if (close || cancel_mask_i[ap_bank_q]) ap_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdram_trk_banks.sv
module sdram_trk_banks #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            act_i,
  input  logic [BANK_W-1:0]               act_bank_i,
  input  logic [ROW_W-1:0]                act_row_i,
  input  logic [(1<<BANK_W)-1:0]          close_mask_i,
  output logic [(1<<BANK_W)-1:0]          open_o,
  output logic [(1<<BANK_W)*ROW_W-1:0]    rows_o
);
  localparam int unsigned NUM_BANKS = 1 << BANK_W;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;
    assign hit = act_i && (act_bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (close_mask_i[b]) begin
        open_q <= 1'b0;
      end else if (hit) begin
        open_q <= 1'b1;
        row_q  <= act_row_i;
      end
    end

    assign open_o[b] = open_q;
    assign rows_o[b*ROW_W +: ROW_W] = row_q;
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned BL_CODE_W = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cke_i,
  input  logic                            cs_ni,
  input  logic                            ras_ni,
  input  logic                            cas_ni,
  input  logic                            we_ni,
  input  logic [BANK_W-1:0]               ba_i,
  input  logic [ROW_W-1:0]                addr_i,
  output logic [NUM_CMD-1:0]              cmd_o,
  output logic                            illegal_o,
  output logic [BANK_W-1:0]               bank_o,
  output logic [ROW_W-1:0]                addr_o,
  output logic [(1<<BANK_W)-1:0]          bank_open_o,
  output logic [(1<<BANK_W)*ROW_W-1:0]    bank_row_o
);
  localparam int unsigned NUM_BANKS = 1 << BANK_W;
  localparam logic [ROW_W-1:0] COL_MASK = ROW_W'((1 << COL_W) - 1);

  logic cke_q;
  pwr_e pwr_q, pwr_d;
  cmd_e cmd;
  logic dec_bad, ok, accept, is_rw, tick, busy, ap_busy;
  logic [NUM_BANKS-1:0] open_vec, cancel_mask, burst_close;
  logic [NUM_CMD-1:0]   cmd_oh;

  sdram_trk_decode u_dec (
    .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni),
    .ap_i(addr_i[AP_BIT]), .cke_prev_i(cke_q), .cke_i(cke_i), .pwr_i(pwr_q),
    .cmd_o(cmd), .bad_o(dec_bad)
  );

  assign tick  = (pwr_q == PWR_RUN) && cke_q;
  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_RDA) || (cmd == CMD_WR) || (cmd == CMD_WRA);

  always_comb begin
    ok = 1'b1;
    case (cmd)
      CMD_ACT:                         ok = !open_vec[ba_i];
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: ok = open_vec[ba_i] && !ap_busy;
      CMD_MRS:                         ok = (open_vec == '0) && !addr_i[BL_CODE_W];
      CMD_REF, CMD_SRE:                ok = (open_vec == '0);
      CMD_PDE:                         ok = !busy;
      default:                         ok = 1'b1;
    endcase
  end

  assign accept = ok && !dec_bad && (cmd != CMD_NONE);

  always_comb begin
    cancel_mask = '0;
    if (accept && cmd == CMD_PRE)  cancel_mask[ba_i] = 1'b1;
    if (accept && cmd == CMD_PALL) cancel_mask = '1;
  end

  always_comb begin
    pwr_d = pwr_q;
    if (accept) begin
      case (cmd)
        CMD_PDE:          pwr_d = PWR_DOWN;
        CMD_SRE:          pwr_d = PWR_SELF;
        CMD_PDX, CMD_SRX: pwr_d = PWR_RUN;
        default:          pwr_d = pwr_q;
      endcase
    end
  end

  always_comb begin
    cmd_oh = '0;
    if (cmd != CMD_NONE) cmd_oh[cmd] = 1'b1;
  end

  sdram_trk_burst #(.BANK_W(BANK_W), .BL_CODE_W(BL_CODE_W)) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .start_i(accept && is_rw),
    .start_ap_i(cmd == CMD_RDA || cmd == CMD_WRA),
    .start_bank_i(ba_i),
    .mrs_i(accept && cmd == CMD_MRS),
    .bl_code_i(addr_i[BL_CODE_W-1:0]),
    .cancel_mask_i(cancel_mask),
    .busy_o(busy), .ap_busy_o(ap_busy), .close_mask_o(burst_close)
  );

  sdram_trk_banks #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .act_i(accept && cmd == CMD_ACT), .act_bank_i(ba_i), .act_row_i(addr_i),
    .close_mask_i(cancel_mask | burst_close),
    .open_o(open_vec), .rows_o(bank_row_o)
  );

  assign bank_open_o = open_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q     <= 1'b1;
      pwr_q     <= PWR_RUN;
      cmd_o     <= '0;
      illegal_o <= 1'b0;
      bank_o    <= '0;
      addr_o    <= '0;
    end else begin
      cke_q     <= cke_i;
      pwr_q     <= pwr_d;
      cmd_o     <= cmd_oh;
      illegal_o <= (cmd != CMD_NONE) && !accept;
      bank_o    <= ba_i;
      addr_o    <= is_rw ? (addr_i & COL_MASK) : addr_i;
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk
  import sdram_trk_pkg::*;
#(
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned COL_W  = 9,
  parameter int unsigned BANK_W = 2
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CMD-1:0]     cmd_o,
  input logic                   illegal_o,
  input logic [BANK_W-1:0]      bank_o,
  input logic [ROW_W-1:0]       addr_o,
  input logic [(1<<BANK_W)-1:0] bank_open_o
);
  logic rw_strobe;
  assign rw_strobe = cmd_o[CMD_RD] || cmd_o[CMD_RDA] || cmd_o[CMD_WR] || cmd_o[CMD_WRA];

  a_r1_onehot_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));
  a_r1_illegal_has_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o != '0));
  a_r2_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_ACT] && !illegal_o) |-> bank_open_o[bank_o]);
  a_r3_column_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_strobe |-> ((addr_o >> COL_W) == '0));
  a_r4_pre_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_PRE] && !illegal_o) |-> !bank_open_o[bank_o]);
  a_r4_pall_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_PALL] && !illegal_o) |-> (bank_open_o == '0));
  a_r5_mrs_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_MRS] && !illegal_o) |-> (bank_open_o == '0));
  a_r7_sre_all_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[CMD_SRE] && !illegal_o) |-> (bank_open_o == '0));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_o(cmd_o), .illegal_o(illegal_o),
  .bank_o(bank_o), .addr_o(addr_o), .bank_open_o(bank_open_o)
);

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  logic [14:0] cmd_o;
  logic illegal_o;
  logic [1:0] bank_o;
  logic [11:0] addr_o;
  logic [3:0] bank_open_o;
  logic [47:0] bank_row_o;

  always #4 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .cmd_o(cmd_o),
    .illegal_o(illegal_o), .bank_o(bank_o), .addr_o(addr_o),
    .bank_open_o(bank_open_o), .bank_row_o(bank_row_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R11";

  // reference model state
  bit m_open[4];
  int m_row[4];
  int m_pwr = 0;            // 0 run, 1 power-down, 2 self refresh
  bit m_ckep = 1;
  int m_bl = 0, m_cnt = 0, m_apbank = 0;
  bit m_apend = 0;
  int e_cmd = -1, e_bank = 0, e_addr = 0;
  bit e_ill = 0;

  task automatic model_step(bit k, bit cs, bit r, bit c, bit w, int b, int a);
    int cc; bit pb, bad, ok, acc, tick, close, busy, any_open;
    pb = 0;
    if (cs) cc = 1;
    else case ({r, c, w})
      3'b111: cc = 0;
      3'b011: cc = 2;
      3'b101: cc = a[10] ? 4 : 3;
      3'b100: cc = a[10] ? 6 : 5;
      3'b010: cc = a[10] ? 8 : 7;
      3'b000: cc = 9;
      3'b001: cc = 10;
      default: begin cc = 0; pb = 1; end
    endcase
    bad = pb;
    if (m_pwr != 0) begin cc = k ? ((m_pwr == 1) ? 14 : 12) : -1; bad = 0; end
    else if (!m_ckep) begin cc = -1; bad = 0; end
    else if (!k) begin
      if ((cc == 0 || cc == 1) && !pb) cc = 13;
      else if (cc == 10) cc = 11;
      else bad = 1;
    end
    any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
    busy = (m_cnt != 0);
    ok = 1;
    case (cc)
      2: ok = !m_open[b];
      3, 4, 5, 6: ok = m_open[b] && !(busy && m_apend);
      9: ok = !any_open && !a[2];
      10, 11: ok = !any_open;
      13: ok = !busy;
      default: ok = 1;
    endcase
    acc = ok && !bad && (cc >= 0);
    e_cmd = cc; e_ill = (cc >= 0) && !acc; e_bank = b;
    e_addr = (cc >= 3 && cc <= 6) ? (a & 'h1FF) : a;
    tick = (m_pwr == 0) && m_ckep;
    close = tick && (m_cnt == 1) && m_apend;
    if (close) m_open[m_apbank] = 0;
    if (acc && cc >= 3 && cc <= 6) begin
      m_cnt = 1 << m_bl; m_apend = (cc == 4 || cc == 6); m_apbank = b;
    end else begin
      if (tick && m_cnt > 0) m_cnt--;
      if (close) m_apend = 0;
    end
    if (acc) case (cc)
      2: begin m_open[b] = 1; m_row[b] = a; end
      7: begin m_open[b] = 0; if (b == m_apbank) m_apend = 0; end
      8: begin for (int i = 0; i < 4; i++) m_open[i] = 0; m_apend = 0; end
      9: m_bl = a & 3;
      11: m_pwr = 2;
      13: m_pwr = 1;
      12, 14: m_pwr = 0;
      default: ;
    endcase
    m_ckep = k;
  endtask

  task automatic compare();
    logic [14:0] ec; logic [3:0] eo; logic [47:0] er;
    ec = (e_cmd < 0) ? 15'd0 : (15'd1 << e_cmd);
    for (int i = 0; i < 4; i++) begin eo[i] = m_open[i]; er[i*12 +: 12] = m_row[i][11:0]; end
    checks++;
    if (cmd_o !== ec || illegal_o !== e_ill || bank_o !== e_bank[1:0] || addr_o !== e_addr[11:0]
        || bank_open_o !== eo || bank_row_o !== er) begin
      fails++;
      $display("FAIL %s: cmd=%h/%h ill=%b/%b bank=%0d/%0d addr=%h/%h open=%b/%b rows=%h/%h",
               tag, cmd_o, ec, illegal_o, e_ill, bank_o, e_bank, addr_o, e_addr[11:0],
               bank_open_o, eo, bank_row_o, er);
    end
  endtask

  task automatic cyc(bit k, bit cs, bit r, bit c, bit w, int b, int a);
    cke = k; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b[1:0]; addr = a[11:0];
    model_step(k, cs, r, c, w, b, a);
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic act(int b, int a);  cyc(1, 0, 0, 1, 1, b, a); endtask
  task automatic rd(int b, int a);   cyc(1, 0, 1, 0, 1, b, a); endtask
  task automatic wr(int b, int a);   cyc(1, 0, 1, 0, 0, b, a); endtask
  task automatic pre(int b, int a);  cyc(1, 0, 0, 1, 0, b, a); endtask
  task automatic mrs(int a);         cyc(1, 0, 0, 0, 0, 0, a); endtask
  task automatic rfr(bit k);         cyc(k, 0, 0, 0, 1, 0, 0); endtask
  task automatic nop(bit k, int n);  for (int i = 0; i < n; i++) cyc(k, 0, 1, 1, 1, 0, 0); endtask
  task automatic dsl(int n);         for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 3, 'hFFF); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = 0; end
    cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
    repeat (3) @(negedge clk);
    tag = "R11"; e_cmd = -1; e_ill = 0; e_bank = 0; e_addr = 0;
    compare();
    rst_ni = 1;
    tag = "R1";  nop(1, 1); dsl(1); cyc(1, 0, 1, 1, 0, 1, 5);
    tag = "R2";  act(0, 'h123); act(0, 'h456); act(3, 'hABC);
    tag = "R3";  rd(0, 'h9FF); wr(3, 'h8AB); rd(1, 'h010); wr(2, 'h011);
    tag = "R5";  mrs(2); pre(0, 'h400); mrs(2); mrs(4); act(1, 'h0F0);
    tag = "R6";  rd(1, 'h405); nop(1, 1); rd(1, 7); nop(1, 3);
    act(2, 'h222); wr(2, 'h408); pre(2, 0); act(2, 'h333); nop(1, 6);
    act(1, 'h0F1); rd(1, 1); rd(1, 2); rd(1, 'h403); nop(1, 4);
    tag = "R4";  pre(2, 0); act(0, 'h010); act(1, 'h020); cyc(1, 0, 0, 1, 0, 2, 'h400);
    tag = "R8";  act(0, 'h555); rd(0, 3); nop(0, 1);
    tag = "R9";  nop(0, 2); nop(1, 1); act(3, 'h777); nop(1, 3);
    tag = "R8";  nop(0, 1); nop(0, 3); nop(1, 1); dsl(1); cyc(0, 1, 1, 1, 1, 0, 0); nop(1, 1);
    tag = "R9";  cyc(0, 0, 0, 1, 1, 1, 'h111); nop(1, 2);
    tag = "R10"; rd(0, 'h404); dsl(4); nop(1, 1);
    tag = "R7";  act(2, 'h066); rfr(1); rfr(0); nop(1, 1); pre(0, 'h400); rfr(1);
    rfr(0); nop(0, 3); nop(1, 1); nop(1, 1); mrs(0);
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      int rnd = $urandom;
      cyc((rnd[2:0] != 0), (rnd[5:3] == 0), rnd[6], rnd[7], rnd[8], rnd[10:9], rnd[22:11]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule